// File: doc/BRIEF.md
# Ternary Route Lookup Table

This block is a sixteen-slot ternary match table that resolves an IPv4 destination address to a next-hop code. Each slot holds a 32-bit pattern, a 32-bit care mask and an 8-bit next-hop value, along with a valid flag. A bit position whose mask bit is 0 is a wildcard and always matches. A search compares the key against every slot at once. When several slots match, a fixed-priority encoder picks the slot with the lowest index.

Software keeps routes ordered so that longer prefixes sit at lower indices. Under that ordering, the lowest-index match is also the longest matching prefix. A single write port loads a slot or invalidates it by index.

Search results are registered and appear on the clock edge after the search request.

Top module: `tcam_lpm_top`

## Requirements
- R1: A slot matches a key when every key bit whose mask bit is 1 equals the stored pattern bit. Bits whose mask bit is 0 are ignored, whatever the stored pattern holds there.
- R2: A slot whose valid flag is clear never matches. Reset clears every valid flag, so any search after reset misses.
- R3: When several valid slots match, the result reports the lowest-indexed one.
- R4: `res_valid` is 1 exactly in the cycle after a cycle with `srch_req` = 1, and 0 otherwise. `res_hit`, `res_index` and `res_hop` carry that search's outcome.
- R5: On a miss, `res_hit` = 0, `res_index` = 0 and `res_hop` = 0.
- R6: A cycle with `upd_en` = 1 and `upd_load` = 1 stores the pattern, mask and next hop into slot `upd_index` and sets its valid flag. A cycle with `upd_en` = 1 and `upd_load` = 0 clears that slot's valid flag.
- R7: An update in the same cycle as a search is not seen by that search. It is seen by searches issued in later cycles.
- R8: A valid slot with an all-zero mask matches every key. This makes it a default route when it is placed at the highest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Update strobe |
| upd_load | input | 1 | 1 = load slot, 0 = invalidate slot |
| upd_index | input | 4 | Slot to update |
| upd_pattern | input | 32 | Pattern to store |
| upd_care | input | 32 | Care mask (1 = compare bit) |
| upd_hop | input | 8 | Next hop to store |
| srch_req | input | 1 | Search request |
| srch_key | input | 32 | Destination address to look up |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_hit | output | 1 | A valid slot matched |
| res_index | output | 4 | Winning slot index |
| res_hop | output | 8 | Winning slot next hop |

## Verification
The in-line assertions check the following on every cycle:
- the result strobe follows each request by exactly one cycle;
- a miss leaves zeroed fields;
- the registered hit flag agrees with the match vector seen at search time;
- a match in slot 0 always wins;
- an invalidated slot stops matching on the next cycle.

Other behaviours depend on concrete table contents and timing, so only the bench's scenarios can show them:
- masked-off pattern bits being ignored;
- the longest prefix winning over a set of overlapping routes;
- a default route catching stray keys;
- an update made during a search staying invisible to that search;
- a reset wiping the table.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    localparam int unsigned TCAM_SLOTS = 16;
    localparam int unsigned TCAM_KEY_W = 32;
    localparam int unsigned TCAM_HOP_W = 8;
endpackage

// File: rtl/tcam_slot.sv
module tcam_slot #(
    parameter int unsigned KEY_W = 32,
    parameter int unsigned HOP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             load,
    input  logic [KEY_W-1:0] pattern_in,
    input  logic [KEY_W-1:0] care_in,
    input  logic [HOP_W-1:0] hop_in,
    input  logic [KEY_W-1:0] key,
    output logic             hit,
    output logic [HOP_W-1:0] hop
);
    logic             live;
    logic [KEY_W-1:0] pattern_q;
    logic [KEY_W-1:0] care_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live      <= 1'b0;
            pattern_q <= '0;
            care_q    <= '0;
            hop       <= '0;
        end else if (sel) begin
            live <= load;
            if (load) begin
                pattern_q <= pattern_in;
                care_q    <= care_in;
                hop       <= hop_in;
            end
        end
    end

    always_comb begin
        hit = live && (((key ^ pattern_q) & care_q) == '0);
    end

    // R6
    invalidate_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !load) |=> !hit);
endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
    parameter int unsigned N = 16,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tcam_lpm_top.sv
module tcam_lpm_top
    import tcam_pkg::*;
#(
    parameter int unsigned SLOTS = TCAM_SLOTS,
    parameter int unsigned KEY_W = TCAM_KEY_W,
    parameter int unsigned HOP_W = TCAM_HOP_W,
    localparam int unsigned IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic             upd_load,
    input  logic [IDX_W-1:0] upd_index,
    input  logic [KEY_W-1:0] upd_pattern,
    input  logic [KEY_W-1:0] upd_care,
    input  logic [HOP_W-1:0] upd_hop,
    input  logic             srch_req,
    input  logic [KEY_W-1:0] srch_key,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_index,
    output logic [HOP_W-1:0] res_hop
);
    logic [SLOTS-1:0] match_vec;
    logic [HOP_W-1:0] slot_hop [SLOTS];
    logic             win_any;
    logic [IDX_W-1:0] win_idx;
    logic [HOP_W-1:0] win_hop;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        tcam_slot #(.KEY_W(KEY_W), .HOP_W(HOP_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (upd_en && (upd_index == IDX_W'(g))),
            .load       (upd_load),
            .pattern_in (upd_pattern),
            .care_in    (upd_care),
            .hop_in     (upd_hop),
            .key        (srch_key),
            .hit        (match_vec[g]),
            .hop        (slot_hop[g])
        );
    end

    tcam_prio #(.N(SLOTS)) u_prio (
        .req (match_vec),
        .any (win_any),
        .idx (win_idx)
    );

    always_comb begin
        win_hop = win_any ? slot_hop[win_idx] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_index <= '0;
            res_hop   <= '0;
        end else begin
            res_valid <= srch_req;
            if (srch_req) begin
                res_hit   <= win_any;
                res_index <= win_any ? win_idx : '0;
                res_hop   <= win_hop;
            end
        end
    end

    // R4
    strobe_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_req |=> res_valid);
    // R4
    no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_req |=> !res_valid);
    // R5
    miss_zeroed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_index == '0 && res_hop == '0));
    // R1
    hit_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_req |=> (res_hit == $past(|match_vec)));
    // R3
    slot0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_req && match_vec[0]) |=> (res_hit && res_index == '0));
endmodule

// File: tb/tb_tcam_lpm_top.sv
module tb_tcam_lpm_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic        upd_load = 1'b0;
    logic [3:0]  upd_index = '0;
    logic [31:0] upd_pattern = '0;
    logic [31:0] upd_care = '0;
    logic [7:0]  upd_hop = '0;
    logic        srch_req = 1'b0;
    logic [31:0] srch_key = '0;
    logic        res_valid, res_hit;
    logic [3:0]  res_index;
    logic [7:0]  res_hop;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tcam_lpm_top dut (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_load(upd_load),
        .upd_index(upd_index), .upd_pattern(upd_pattern), .upd_care(upd_care),
        .upd_hop(upd_hop), .srch_req(srch_req), .srch_key(srch_key),
        .res_valid(res_valid), .res_hit(res_hit), .res_index(res_index),
        .res_hop(res_hop)
    );

    // {key, hit, index, hop}
    localparam int NV = 6;
    localparam logic [44:0] VEC [NV] = '{
        {32'h0A01_0203, 1'b1, 4'd0, 8'h11},
        {32'h0A01_0204, 1'b1, 4'd1, 8'h22},
        {32'h0A01_FF00, 1'b1, 4'd2, 8'h33},
        {32'h0A02_0000, 1'b1, 4'd4, 8'h55},
        {32'hC0A8_0101, 1'b1, 4'd3, 8'h44},
        {32'h0B00_0000, 1'b0, 4'd0, 8'h00}
    };

    task automatic check(input string req, input logic [12:0] got, input logic [12:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got hit/idx/hop=%h expected %h", req, got, exp);
        end
    endtask

    task automatic put(input logic ld, input logic [3:0] ix, input logic [31:0] p,
                       input logic [31:0] m, input logic [7:0] h);
        @(negedge clk);
        upd_en = 1'b1; upd_load = ld; upd_index = ix;
        upd_pattern = p; upd_care = m; upd_hop = h;
        @(negedge clk);
        upd_en = 1'b0;
    endtask

    task automatic look(input string req, input logic [31:0] k, input logic [12:0] exp);
        @(negedge clk);
        srch_req = 1'b1; srch_key = k;
        @(negedge clk);
        srch_req = 1'b0;
        check({req, " strobe"}, {12'd0, res_valid}, 13'd1);
        check(req, {res_hit, res_index, res_hop}, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 reset idle", {12'd0, res_valid}, 13'd0);
        rst_n = 1'b1;
        look("R2 empty table", 32'h0A01_0203, 13'd0);
        put(1, 0, 32'h0A01_0203, 32'hFFFF_FFFF, 8'h11);
        put(1, 1, 32'h0A01_0200, 32'hFFFF_FF00, 8'h22);
        put(1, 2, 32'h0A01_0000, 32'hFFFF_0000, 8'h33);
        put(1, 3, 32'hC0A8_0000, 32'hFFFF_0000, 8'h44);
        put(1, 4, 32'h0A00_0000, 32'hFF00_0000, 8'h55);
        // R3 R1 R5 vector walk
        for (int i = 0; i < NV; i++) begin
            look("R3 vector", VEC[i][44:13], VEC[i][12:0]);
        end
        // R4: no request, no strobe
        @(negedge clk);
        check("R4 idle strobe", {12'd0, res_valid}, 13'd0);
        // R1: pattern bits under zero care bits ignored
        put(1, 14, 32'h0BFF_FFFF, 32'hFF00_0000, 8'h77);
        look("R1 masked bits", 32'h0B12_3456, {1'b1, 4'd14, 8'h77});
        // R8: default route
        put(1, 15, 32'hDEAD_BEEF, 32'h0000_0000, 8'hEE);
        look("R8 default", 32'h7F00_0001, {1'b1, 4'd15, 8'hEE});
        // R6: invalidate slot 0
        put(0, 0, 32'h0, 32'h0, 8'h0);
        look("R6 invalidate", 32'h0A01_0203, {1'b1, 4'd1, 8'h22});
        // R7: update together with a search
        @(negedge clk);
        srch_req = 1'b1; srch_key = 32'h0A01_0203;
        upd_en = 1'b1; upd_load = 1'b1; upd_index = 4'd0;
        upd_pattern = 32'h0A01_0203; upd_care = 32'hFFFF_FFFF; upd_hop = 8'h99;
        @(negedge clk);
        srch_req = 1'b0; upd_en = 1'b0;
        check("R7 same cycle", {res_hit, res_index, res_hop}, {1'b1, 4'd1, 8'h22});
        look("R7 later", 32'h0A01_0203, {1'b1, 4'd0, 8'h99});
        // R6: reload keeps the new hop
        look("R6 reload", 32'h0A01_0203, {1'b1, 4'd0, 8'h99});
        // R2: reset wipes the table
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        look("R2 after reset", 32'h7F00_0001, 13'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule